// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block gathers a set of peripheral interrupt lines, 48 by default, and offers one of them at a time to a processor core. Each line carries four pieces of state: an enable bit, a pending bit, an active bit and a priority. Software reaches them over a simple 32-bit register bus. Enable and pending state each have one bank that sets and a second bank that clears, so no bit is ever changed by a read-modify-write. There is also a word that pends one line by its number, and a global mask bit.

A rising edge on a peripheral line marks that line pending. The arbiter looks at the lines that are pending and enabled and picks the most urgent one. It offers that line to the core only if the line is more urgent than the interrupt now running. When the core takes the offer, the line moves from pending to active and the running priority is saved on a small stack. An end-of-service strobe undoes the most recent take.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable, pending, active and priority bit reads 0, the mask reads 0 and `irq_req` is low.
- R2: A bit written as 1 at word 0x000 (lines 0-31) or 0x004 (lines 32-47) sets that line's enable. The same bit written as 1 at 0x080 or 0x084 clears it. Bits written as 0 change nothing. Both banks read back the enable bits, and bits beyond the last line read 0.
- R3: Pending bits are set through 0x100/0x104 and cleared through 0x180/0x184, with the same write-1 rule as R2. If a set and a clear reach the same pending bit in one cycle, the bit ends up set.
- R4: A 0-to-1 change on `irq_lines[i]` sets pending bit i in the clock edge where the high level is first seen. A line held high does not pend again after its pending bit has been cleared.
- R5: The active bits read at 0x200/0x204. Bus writes to these words change nothing.
- R6: Line i has a priority byte at byte i from 0x300 (4 lines per word, line 4k in bits [7:0]). Only bits [7:4] are kept, bits [3:0] read 0, and a lower value is more urgent.
- R7: A write to 0xE00 with a line number in bits [7:0] sets that line's pending bit. A number of 48 or more is ignored.
- R8: Bit 0 of 0xD00 is the global mask and reads back. While it is 1, `irq_req` stays low and pending bits are kept.
- R9: Among lines that are pending and enabled, the lowest priority value wins and a tie goes to the lowest line number. The winner's number is shown on `irq_id`.
- R10: `irq_req` rises only if the winner's priority is strictly lower than the running priority. With nothing active, every priority qualifies.
- R11: `irq_ack` while `irq_req` is high clears the winner's pending bit, sets its active bit and makes its priority the running one. `irq_eos` clears the active bit of the most recent take and restores the running priority from before it.
- R12: With STACK_DEPTH takes outstanding, `irq_req` stays low. If `irq_ack` and `irq_eos` arrive in the same cycle, only the end of service is acted on, and an end of service with nothing active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 48 | Peripheral request lines, pended on a rising edge |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | An interrupt is offered to the core |
| irq_id | output | 6 | Number of the line on offer |
| irq_ack | input | 1 | Core takes the offered line |
| irq_eos | input | 1 | Core ends service of the most recent take |

## Verification
The hardest state to reach from the ports is a full nesting stack with a strictly more urgent line still pending. The bench builds it step by step. It writes priorities so that each new line is more urgent than the one running, pends each line through the trigger word, and acknowledges it once it is offered. It then checks that the next, still more urgent line is held back until an end of service frees a stack entry. A set-pending and a clear-pending on the same bit in one cycle is also hard to reach. The bench gets there by raising a peripheral line during the same cycle as a clear-pending write.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic [3:0] {
    BK_EN_SET, BK_EN_CLR, BK_PD_SET, BK_PD_CLR,
    BK_ACT, BK_PRIO, BK_TRIG, BK_MASK, BK_NONE
  } bank_t;

  // Address decode: word-aligned accesses only.
  function automatic bank_t decode_bank(input logic [11:0] a);
    bank_t b;
    if (a[1:0] != 2'b00)       b = BK_NONE;
    else if (a == 12'hE00)     b = BK_TRIG;
    else if (a == 12'hD00)     b = BK_MASK;
    else begin
      case (a[11:7])
        5'd0:       b = BK_EN_SET;
        5'd1:       b = BK_EN_CLR;
        5'd2:       b = BK_PD_SET;
        5'd3:       b = BK_PD_CLR;
        5'd4:       b = BK_ACT;
        5'd6, 5'd7: b = BK_PRIO;
        default:    b = BK_NONE;
      endcase
    end
    return b;
  endfunction

  // Bits of a priority word that always read zero.
  function automatic logic [31:0] prio_zero_mask(input int pbits);
    logic [7:0] m;
    m = 8'((1 << (8 - pbits)) - 1);
    return {4{m}};
  endfunction

endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int N_IRQ     = 48,
  parameter int PRIO_BITS = 4,
  parameter int ID_W      = $clog2(N_IRQ)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_IRQ-1:0]                 lines_i,
  input  logic                             we_i,
  input  logic [11:0]                      addr_i,
  input  logic [31:0]                      wdata_i,
  output logic [31:0]                      rdata_o,
  input  logic                             take_i,
  input  logic [ID_W-1:0]                  take_id_i,
  input  logic                             drop_i,
  input  logic [ID_W-1:0]                  drop_id_i,
  output logic [N_IRQ-1:0]                 en_o,
  output logic [N_IRQ-1:0]                 pend_o,
  output logic [N_IRQ-1:0]                 act_o,
  output logic [N_IRQ-1:0][PRIO_BITS-1:0]  prio_o,
  output logic                             gmask_o
);
  localparam int NWORDS  = (N_IRQ + 31) / 32;
  localparam int NPWORDS = (N_IRQ + 3) / 4;
  localparam int PAD     = NWORDS * 32;

  logic [N_IRQ-1:0] en_q, pend_q, act_q, prev_q;
  logic [N_IRQ-1:0][PRIO_BITS-1:0] prio_q;
  logic gmask_q;

  bank_t bank;
  assign bank = decode_bank(addr_i);

  // Named write events, one vector per kind.
  logic [N_IRQ-1:0] en_set, en_clr, pd_set, pd_clr, edge_set, trig_set;
  logic [N_IRQ-1:0] take_mask, drop_mask;
  logic [N_IRQ-1:0] prio_we;
  logic             trig_valid;

  assign edge_set   = lines_i & ~prev_q;
  assign trig_valid = we_i && (bank == BK_TRIG) &&
                      ({24'd0, wdata_i[7:0]} < 32'(N_IRQ));

  always_comb begin
    for (int i = 0; i < N_IRQ; i++) begin
      logic hit, b;
      hit          = (addr_i[6:2] == 5'(i / 32));
      b            = wdata_i[i % 32];
      en_set[i]    = we_i && bank == BK_EN_SET && hit && b;
      en_clr[i]    = we_i && bank == BK_EN_CLR && hit && b;
      pd_set[i]    = we_i && bank == BK_PD_SET && hit && b;
      pd_clr[i]    = we_i && bank == BK_PD_CLR && hit && b;
      trig_set[i]  = trig_valid && (wdata_i[7:0] == 8'(i));
      take_mask[i] = take_i && (take_id_i == ID_W'(i));
      drop_mask[i] = drop_i && (drop_id_i == ID_W'(i));
      prio_we[i]   = we_i && bank == BK_PRIO && (addr_i[7:2] == 6'(i / 4));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pend_q  <= '0;
      act_q   <= '0;
      prev_q  <= '0;
      prio_q  <= '0;
      gmask_q <= 1'b0;
    end else begin
      prev_q <= lines_i;
      en_q   <= (en_q | en_set) & ~en_clr;
      // Set sources win over clear sources on the same bit.
      pend_q <= (pend_q & ~(pd_clr | take_mask)) | pd_set | edge_set | trig_set;
      act_q  <= (act_q | take_mask) & ~drop_mask;
      if (we_i && bank == BK_MASK) gmask_q <= wdata_i[0];
      for (int i = 0; i < N_IRQ; i++)
        if (prio_we[i]) prio_q[i] <= wdata_i[(i % 4) * 8 + 7 -: PRIO_BITS];
    end
  end

  assign en_o    = en_q;
  assign pend_o  = pend_q;
  assign act_o   = act_q;
  assign prio_o  = prio_q;
  assign gmask_o = gmask_q;

  logic [PAD-1:0] en_pad, pend_pad, act_pad;
  assign en_pad   = PAD'(en_q);
  assign pend_pad = PAD'(pend_q);
  assign act_pad  = PAD'(act_q);

  always_comb begin
    rdata_o = '0;
    case (bank)
      BK_EN_SET, BK_EN_CLR:
        for (int k = 0; k < NWORDS; k++)
          if (addr_i[6:2] == 5'(k)) rdata_o = en_pad[k*32 +: 32];
      BK_PD_SET, BK_PD_CLR:
        for (int k = 0; k < NWORDS; k++)
          if (addr_i[6:2] == 5'(k)) rdata_o = pend_pad[k*32 +: 32];
      BK_ACT:
        for (int k = 0; k < NWORDS; k++)
          if (addr_i[6:2] == 5'(k)) rdata_o = act_pad[k*32 +: 32];
      BK_PRIO:
        for (int k = 0; k < NPWORDS; k++)
          if (addr_i[7:2] == 6'(k))
            for (int b = 0; b < 4; b++)
              if (k * 4 + b < N_IRQ)
                rdata_o[b*8 + 7 -: PRIO_BITS] = prio_q[k*4 + b];
      BK_MASK: rdata_o = {31'd0, gmask_q};
      default: rdata_o = '0;
    endcase
  end

  // R6: the unimplemented low bits of every priority byte read zero.
  p_prio_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank == BK_PRIO) |-> ((rdata_o & prio_zero_mask(PRIO_BITS)) == 32'd0));

  // R3: a set source on a bit leaves that bit pending after the edge.
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pd_set & pd_clr)) == 1'b0 && (|((edge_set | trig_set) & pd_clr)) |=>
    (|pend_q));

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int N_IRQ     = 48,
  parameter int PRIO_BITS = 4,
  parameter int ID_W      = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0]                cand_i,
  input  logic [N_IRQ-1:0][PRIO_BITS-1:0] prio_i,
  input  logic                            gmask_i,
  input  logic                            full_i,
  input  logic [PRIO_BITS:0]              run_prio_i,
  output logic                            req_o,
  output logic [ID_W-1:0]                 id_o,
  output logic [PRIO_BITS:0]              win_prio_o
);
  localparam logic [PRIO_BITS:0] IDLE = (PRIO_BITS+1)'(1 << PRIO_BITS);

  // Strictly-less comparison on an upward scan keeps the lowest number on ties.
  function automatic logic more_urgent(input logic [PRIO_BITS:0] a,
                                       input logic [PRIO_BITS:0] b);
    return a < b;
  endfunction

  logic found;

  always_comb begin
    found      = 1'b0;
    id_o       = '0;
    win_prio_o = IDLE;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cand_i[i] && more_urgent({1'b0, prio_i[i]}, win_prio_o)) begin
        found      = 1'b1;
        id_o       = ID_W'(i);
        win_prio_o = {1'b0, prio_i[i]};
      end
    end
  end

  assign req_o = found && !gmask_i && !full_i && more_urgent(win_prio_o, run_prio_i);

endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 6,
  parameter int PW    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic [ID_W-1:0] push_id_i,
  input  logic [PW-1:0]   push_prio_i,
  input  logic            pop_i,
  output logic [PW-1:0]   run_prio_o,
  output logic [ID_W-1:0] top_id_o,
  output logic            full_o,
  output logic            empty_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] IDLE = PW'(1 << (PW - 1));

  logic [DEPTH-1:0][ID_W-1:0] id_mem;
  logic [DEPTH-1:0][PW-1:0]   prio_mem;
  logic [CNT_W-1:0]           cnt_q;
  logic [PW-1:0]              run_q;
  logic [PW-1:0]              top_prio;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign depth_o = cnt_q;

  always_comb begin
    top_id_o = '0;
    top_prio = IDLE;
    for (int k = 0; k < DEPTH; k++)
      if (cnt_q == CNT_W'(k + 1)) begin
        top_id_o = id_mem[k];
        top_prio = prio_mem[k];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      run_q    <= IDLE;
      id_mem   <= '0;
      prio_mem <= '0;
    end else if (pop_i) begin
      cnt_q <= cnt_q - 1'b1;
      run_q <= top_prio;
    end else if (push_i) begin
      for (int k = 0; k < DEPTH; k++)
        if (cnt_q == CNT_W'(k)) begin
          id_mem[k]   <= push_id_i;
          prio_mem[k] <= run_q;
        end
      cnt_q <= cnt_q + 1'b1;
      run_q <= push_prio_i;
    end
  end

  assign run_prio_o = run_q;

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
  // R11: each push makes the running priority strictly more urgent.
  p_push_more_urgent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> (run_q < $past(run_q)));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_IRQ       = 48,
  parameter int PRIO_BITS   = 4,
  parameter int STACK_DEPTH = 4,
  localparam int ID_W       = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic             bus_we,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_req,
  output logic [ID_W-1:0]  irq_id,
  input  logic             irq_ack,
  input  logic             irq_eos
);
  localparam int PW = PRIO_BITS + 1;

  logic [N_IRQ-1:0]                en_w, pend_w, act_w;
  logic [N_IRQ-1:0][PRIO_BITS-1:0] prio_w;
  logic                            gmask_w, full_w, empty_w;
  logic [PW-1:0]                   run_prio_w, win_prio_w;
  logic [ID_W-1:0]                 top_id_w;
  logic [$clog2(STACK_DEPTH+1)-1:0] depth_w;

  // Handshake events as named wires.
  logic take_w, drop_w;
  assign drop_w = irq_eos && !empty_w;
  assign take_w = irq_ack && irq_req && !irq_eos;

  prio_irq_regs #(.N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .lines_i(irq_lines),
    .we_i(bus_we), .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .take_i(take_w), .take_id_i(irq_id), .drop_i(drop_w), .drop_id_i(top_id_w),
    .en_o(en_w), .pend_o(pend_w), .act_o(act_w), .prio_o(prio_w), .gmask_o(gmask_w)
  );

  prio_irq_arb #(.N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_arb (
    .cand_i(pend_w & en_w), .prio_i(prio_w), .gmask_i(gmask_w), .full_i(full_w),
    .run_prio_i(run_prio_w), .req_o(irq_req), .id_o(irq_id), .win_prio_o(win_prio_w)
  );

  prio_irq_stack #(.DEPTH(STACK_DEPTH), .ID_W(ID_W), .PW(PW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(take_w), .push_id_i(irq_id),
    .push_prio_i(win_prio_w), .pop_i(drop_w), .run_prio_o(run_prio_w),
    .top_id_o(top_id_w), .full_o(full_w), .empty_o(empty_w), .depth_o(depth_w)
  );

  p_req_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_w[irq_id] && en_w[irq_id]));
  p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_w |-> !irq_req);
  p_ack_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> act_w[$past(irq_id)]);
  p_depth_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_w) == int'(depth_w));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] irq_lines = '0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [5:0]  irq_id;
  logic        irq_ack = 1'b0;
  logic        irq_eos = 1'b0;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.STACK_DEPTH(2)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_id(irq_id), .irq_ack(irq_ack), .irq_eos(irq_eos)
  );

  typedef struct packed {
    logic [11:0] wa;
    logic [31:0] wd;
    logic [11:0] ra;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t TBL [0:13] = '{
    '{12'h000, 32'h0000_00F0, 12'h000, 32'h0000_00F0},  // R2 set
    '{12'h080, 32'h0000_0030, 12'h080, 32'h0000_00C0},  // R2 clear
    '{12'h004, 32'h0000_8001, 12'h084, 32'h0000_8001},  // R2 upper word
    '{12'h084, 32'h0000_FFFF, 12'h004, 32'h0000_0000},  // R2 pad bits zero
    '{12'h100, 32'h0000_0005, 12'h100, 32'h0000_0005},  // R3 set
    '{12'h180, 32'h0000_0001, 12'h180, 32'h0000_0004},  // R3 clear
    '{12'h180, 32'h0000_0004, 12'h100, 32'h0000_0000},  // R3 clear rest
    '{12'h300, 32'hFFFF_FFFF, 12'h300, 32'hF0F0_F0F0},  // R6 low nibble
    '{12'h32C, 32'h1234_5678, 12'h32C, 32'h1030_5070},  // R6 last word
    '{12'h200, 32'hFFFF_FFFF, 12'h200, 32'h0000_0000},  // R5 read-only
    '{12'hE00, 32'd47,        12'h104, 32'h0000_8000},  // R7 trigger
    '{12'hE00, 32'd48,        12'h104, 32'h0000_8000},  // R7 out of range
    '{12'hD00, 32'hFFFF_FFFF, 12'hD00, 32'h0000_0001},  // R8 mask on
    '{12'hD00, 32'h0000_0000, 12'hD00, 32'h0000_0000}   // R8 mask off
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic chk_req(input string tag, input logic r, input logic [5:0] id);
    #1;
    chk({tag, " req"}, {31'd0, irq_req}, {31'd0, r});
    if (r) chk({tag, " id"}, {26'd0, irq_id}, {26'd0, id});
  endtask

  task automatic pulse(input logic a, input logic e);
    @(negedge clk);
    irq_ack = a; irq_eos = e;
    @(negedge clk);
    irq_ack = 1'b0; irq_eos = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 enable", 12'h000, 32'h0);
    rd("R1 pending", 12'h100, 32'h0);
    rd("R1 active", 12'h200, 32'h0);
    rd("R1 prio", 12'h300, 32'h0);
    rd("R1 mask", 12'hD00, 32'h0);
    chk_req("R1", 1'b0, 6'd0);

    foreach (TBL[i]) begin
      wr(TBL[i].wa, TBL[i].wd);
      rd($sformatf("table %0d", i), TBL[i].ra, TBL[i].exp);
    end
    wr(12'h184, 32'h0000_FFFF);
    wr(12'h300, 32'h0);
    wr(12'h32C, 32'h0);

    // R4: edge pends, held level does not re-pend
    wr(12'h000, 32'h0000_0400);
    @(negedge clk); irq_lines[10] = 1'b1;
    @(negedge clk);
    rd("R4 edge pends", 12'h100, 32'h0000_0400);
    chk_req("R4 offer", 1'b1, 6'd10);
    wr(12'h180, 32'h0000_0400);
    @(negedge clk);
    rd("R4 level no repend", 12'h100, 32'h0);
    chk_req("R4 no offer", 1'b0, 6'd0);
    irq_lines[10] = 1'b0;

    // R3: set beats clear in the same cycle
    @(negedge clk);
    irq_lines[11] = 1'b1;
    bus_we = 1'b1; bus_addr = 12'h180; bus_wdata = 32'h0000_0800;
    @(negedge clk);
    bus_we = 1'b0;
    rd("R3 set wins", 12'h100, 32'h0000_0800);
    wr(12'h180, 32'h0000_0800);
    irq_lines[11] = 1'b0;

    // R9: lowest value, then lowest number
    wr(12'h300, 32'h5000_0000);
    wr(12'h304, 32'h0000_3000);
    wr(12'h308, 32'h0000_3000);
    wr(12'h000, 32'h0000_0228);
    wr(12'h100, 32'h0000_0228);
    chk_req("R9 tie lowest number", 1'b1, 6'd5);

    // R8: mask holds off, pending kept
    wr(12'hD00, 32'h1);
    chk_req("R8 masked", 1'b0, 6'd0);
    rd("R8 pending kept", 12'h100, 32'h0000_0228);
    wr(12'hD00, 32'h0);
    chk_req("R8 unmasked", 1'b1, 6'd5);

    // R11 take, R10 equal priority not offered
    pulse(1'b1, 1'b0);
    rd("R11 active set", 12'h200, 32'h0000_0020);
    rd("R11 pending cleared", 12'h100, 32'h0000_0208);
    chk_req("R10 equal blocked", 1'b0, 6'd0);

    // R10 preemption by strictly lower value
    wr(12'h300, 32'h5010_0000);
    wr(12'h000, 32'h0000_0004);
    wr(12'hE00, 32'd2);
    chk_req("R10 preempt", 1'b1, 6'd2);
    pulse(1'b1, 1'b0);
    rd("R11 nested active", 12'h200, 32'h0000_0024);
    chk_req("R10 running blocks", 1'b0, 6'd0);

    // R11 end of service restores
    pulse(1'b0, 1'b1);
    rd("R11 eos pops", 12'h200, 32'h0000_0020);
    chk_req("R11 restored prio", 1'b0, 6'd0);
    pulse(1'b0, 1'b1);
    rd("R11 all idle", 12'h200, 32'h0);
    chk_req("R10 idle offers", 1'b1, 6'd9);

    // R12: ack with eos together, eos on empty ignored
    pulse(1'b1, 1'b1);
    rd("R12 ack+eos active", 12'h200, 32'h0);
    rd("R12 ack+eos pending", 12'h100, 32'h0000_0208);

    // R12: depth limit (bench stack depth 2)
    pulse(1'b1, 1'b0);
    rd("R12 first take", 12'h200, 32'h0000_0200);
    wr(12'h30C, 32'h0000_1020);
    wr(12'h000, 32'h0000_3000);
    wr(12'hE00, 32'd12);
    chk_req("R12 second offer", 1'b1, 6'd12);
    pulse(1'b1, 1'b0);
    rd("R12 two active", 12'h200, 32'h0000_1200);
    wr(12'hE00, 32'd13);
    chk_req("R12 full blocks", 1'b0, 6'd0);
    pulse(1'b0, 1'b1);
    rd("R12 after pop", 12'h200, 32'h0000_0200);
    chk_req("R12 freed offers", 1'b1, 6'd13);

    finish_run();
  end

endmodule